// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Through Cache with DMA Snoop Invalidation

This block sits between a processor and a slower memory port. A word address is cut into a tag, a set number and a word position inside a line. The set number picks one of sixteen sets. The four tags of that set are compared with the address tag at once, and a matching way supplies its word through a four-to-one select. Every line keeps a line-valid flag and one valid flag per word. A processor store therefore never has to fetch the rest of its line. Only the stored word becomes usable, and a later read of an empty word pulls in just the missing words.

Every store is forwarded to memory, so the cache holds no modified data of its own. A second, invalidate-only input reports writes made to memory by a DMA engine. When such an address matches a live line, that whole line is dropped. When all four ways of a set are live and a miss needs a place, the least recently touched way is overwritten.

Top module: `cache_top`

## Requirements
- R1: After reset every line is empty. `cpu_ready` and `mem_req` stay low until a request arrives, and the first read of any address goes to memory.
- R2: Address bits [1:0] give the word within the line, bits [5:2] give the set, and bits [11:6] give the tag. Memory reads for a fill carry the request's tag and set with the fetched word's position in bits [1:0].
- R3: A read that hits a valid word asserts `cpu_ready` combinationally in the request cycle. It returns the stored word and makes no memory access.
- R4: A read miss issues one memory read for each invalid word of the line, in ascending word order. `cpu_ready` rises in the cycle the requested word is acknowledged, with `cpu_rdata` equal to `mem_rdata`.
- R5: Every store makes exactly one memory write with its own address and data, and `cpu_ready` rises with that write's acknowledge. A store that hits updates the cached word, so a later read returns it without memory traffic.
- R6: A store that misses reads nothing from memory and marks only the stored word valid. A read of that word then hits. A read of another word of the line fetches only the three invalid words.
- R7: A DMA write whose address matches a live line invalidates the whole line. The next read of that line refetches all four words and returns the new memory contents.
- R8: A DMA write that matches no live line, either because the tag differs or because the set differs, leaves the cache unchanged.
- R9: When a DMA write and a processor access meet on the same line in the same cycle, the invalidation is applied first and the processor access is treated as a miss.
- R10: On a miss, an invalid way of the set is used first. When all four ways are live, the least recently used way is replaced. Hits and allocations both count as uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 12 | Processor word address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge of the pending memory request |
| dma_wr_valid | input | 1 | A DMA write to memory is seen this cycle |
| dma_wr_addr | input | 12 | Word address of that DMA write |

## Verification
A DMA invalidation and a processor lookup can fall on the same line in the same clock edge. The line would then be both dropped and used. The bench provokes this by raising `cpu_req` and `dma_wr_valid` at the same falling edge, with the same address, against a line already resident. It changes the memory word beforehand, so a stale hit and a correct refill return different values. It judges the outcome by the count of memory reads (four, not zero) and by the returned word matching the new memory contents.

// File: rtl/cache_pkg.sv
package cache_pkg;

    localparam int WAYS   = 4;
    localparam int SETS   = 16;
    localparam int WORDS  = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam int OFF_W  = $clog2(WORDS);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SET_W-1:0]  set_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [WORDS-1:0]  wmask_t;

    typedef struct packed {
        tag_t tag;
        set_t set;
        off_t off;
    } addr_fields_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WRITE
    } ctrl_state_t;

    function automatic wmask_t word_bit(off_t o);
        return wmask_t'(1) << o;
    endfunction

    function automatic off_t lowest_pending(wmask_t m);
        off_t r = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (m[i]) r = off_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match
    import cache_pkg::*;
(
    input  tag_t [WAYS-1:0] way_tags,
    input  logic [WAYS-1:0] way_live,
    input  tag_t            probe_tag,
    output logic [WAYS-1:0] match,
    output logic            any_match,
    output way_t            match_way
);

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_live[g] && (way_tags[g] == probe_tag);
    end

    always_comb begin
        any_match = |match;
        match_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) match_way = way_t'(i);
        end
    end

endmodule

// File: rtl/cache_lru.sv
module cache_lru
    import cache_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic touch,
    input  set_t touch_set,
    input  way_t touch_way,
    input  set_t look_set,
    output way_t oldest_way
);

    localparam way_t AGE_MAX = way_t'(WAYS - 1);

    way_t [WAYS-1:0] age_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= way_t'(w);
                end
            end
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (way_t'(w) == touch_way) begin
                    age_q[touch_set][w] <= '0;
                end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
                    age_q[touch_set][w] <= age_q[touch_set][w] + way_t'(1);
                end
            end
        end
    end

    always_comb begin
        oldest_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[look_set][w] == AGE_MAX) oldest_way = way_t'(w);
        end
    end

endmodule

// File: rtl/cache_data_ram.sv
module cache_data_ram
    import cache_pkg::*;
(
    input  logic  clk,
    input  set_t  rd_set,
    input  way_t  rd_way,
    input  off_t  rd_off,
    output word_t rd_data,
    input  logic  wr_en,
    input  set_t  wr_set,
    input  way_t  wr_way,
    input  off_t  wr_off,
    input  word_t wr_data
);

    localparam int DEPTH = SETS * WAYS * WORDS;

    word_t store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[{wr_set, wr_way, wr_off}] <= wr_data;
    end

    assign rd_data = store_q[{rd_set, rd_way, rd_off}];

endmodule

// File: rtl/cache_top.sv
module cache_top
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              dma_wr_valid,
    input  logic [ADDR_W-1:0] dma_wr_addr
);

    // Line state arrays
    tag_t   [WAYS-1:0] tag_q  [SETS];
    logic   [WAYS-1:0] live_q [SETS];
    wmask_t [WAYS-1:0] wval_q [SETS];

    // Controller registers
    ctrl_state_t  state_q;
    addr_fields_t req_q;
    way_t         way_q;
    wmask_t       need_q;
    word_t        wdata_q;

    addr_fields_t cpu_f, dma_f;
    assign cpu_f = addr_fields_t'(cpu_addr);
    assign dma_f = addr_fields_t'(dma_wr_addr);

    // Snoop side compare
    logic [WAYS-1:0] snp_match, snp_kill;
    logic            snp_any;
    way_t            snp_way;

    cache_tag_match u_snoop_cmp (
        .way_tags  (tag_q[dma_f.set]),
        .way_live  (live_q[dma_f.set]),
        .probe_tag (dma_f.tag),
        .match     (snp_match),
        .any_match (snp_any),
        .match_way (snp_way)
    );

    assign snp_kill = dma_wr_valid ? snp_match : '0;

    // Processor side compare, with same-cycle snoop applied first
    logic [WAYS-1:0] cpu_live, cpu_match;
    logic            cpu_tag_hit;
    way_t            cpu_hit_way;

    assign cpu_live = live_q[cpu_f.set] &
                      ~((dma_f.set == cpu_f.set) ? snp_kill : '0);

    cache_tag_match u_cpu_cmp (
        .way_tags  (tag_q[cpu_f.set]),
        .way_live  (cpu_live),
        .probe_tag (cpu_f.tag),
        .match     (cpu_match),
        .any_match (cpu_tag_hit),
        .match_way (cpu_hit_way)
    );

    logic word_ok, read_hit, idle_go;
    assign word_ok  = wval_q[cpu_f.set][cpu_hit_way][cpu_f.off];
    assign read_hit = cpu_tag_hit && word_ok;
    assign idle_go  = (state_q == ST_IDLE) && cpu_req;

    // Victim choice: an empty way first, else the oldest
    way_t lru_oldest, victim, alloc_way;

    cache_lru u_lru (
        .clk        (clk),
        .rst        (rst),
        .touch      (idle_go),
        .touch_set  (cpu_f.set),
        .touch_way  (alloc_way),
        .look_set   (cpu_f.set),
        .oldest_way (lru_oldest)
    );

    always_comb begin
        victim = lru_oldest;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!cpu_live[i]) victim = way_t'(i);
        end
    end

    assign alloc_way = cpu_tag_hit ? cpu_hit_way : victim;

    // Fill progress
    off_t   fill_off;
    wmask_t need_after;
    logic   fill_ack;
    assign fill_off   = lowest_pending(need_q);
    assign need_after = need_q & ~word_bit(fill_off);
    assign fill_ack   = (state_q == ST_FILL) && mem_ack;

    // Data array
    word_t ram_rdata;
    logic  ram_we;
    set_t  ram_wset;
    way_t  ram_wway;
    off_t  ram_woff;
    word_t ram_wdata;

    always_comb begin
        if (fill_ack) begin
            ram_we    = 1'b1;
            ram_wset  = req_q.set;
            ram_wway  = way_q;
            ram_woff  = fill_off;
            ram_wdata = mem_rdata;
        end else begin
            ram_we    = idle_go && cpu_we;
            ram_wset  = cpu_f.set;
            ram_wway  = alloc_way;
            ram_woff  = cpu_f.off;
            ram_wdata = cpu_wdata;
        end
    end

    cache_data_ram u_data (
        .clk     (clk),
        .rd_set  (cpu_f.set),
        .rd_way  (cpu_hit_way),
        .rd_off  (cpu_f.off),
        .rd_data (ram_rdata),
        .wr_en   (ram_we),
        .wr_set  (ram_wset),
        .wr_way  (ram_wway),
        .wr_off  (ram_woff),
        .wr_data (ram_wdata)
    );

    // Outputs
    assign cpu_ready = (idle_go && !cpu_we && read_hit) ||
                       (fill_ack && (fill_off == req_q.off)) ||
                       ((state_q == ST_WRITE) && mem_ack);
    assign cpu_rdata = (state_q == ST_FILL) ? mem_rdata : ram_rdata;
    assign mem_req   = (state_q != ST_IDLE);
    assign mem_we    = (state_q == ST_WRITE);
    assign mem_addr  = (state_q == ST_WRITE) ? addr_t'(req_q)
                                             : addr_t'({req_q.tag, req_q.set, fill_off});
    assign mem_wdata = wdata_q;

    // State update: snoop clears come first, later writes in the same edge win
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            way_q   <= '0;
            need_q  <= '0;
            wdata_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                tag_q[s]  <= '0;
                live_q[s] <= '0;
                wval_q[s] <= '0;
            end
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (snp_kill[w]) begin
                    live_q[dma_f.set][w] <= 1'b0;
                    wval_q[dma_f.set][w] <= '0;
                end
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        req_q   <= cpu_f;
                        way_q   <= alloc_way;
                        wdata_q <= cpu_wdata;
                        if (cpu_we) begin
                            if (!cpu_tag_hit) begin
                                tag_q[cpu_f.set][alloc_way]  <= cpu_f.tag;
                                live_q[cpu_f.set][alloc_way] <= 1'b1;
                                wval_q[cpu_f.set][alloc_way] <= word_bit(cpu_f.off);
                            end else begin
                                wval_q[cpu_f.set][alloc_way][cpu_f.off] <= 1'b1;
                            end
                            state_q <= ST_WRITE;
                        end else if (!read_hit) begin
                            if (!cpu_tag_hit) begin
                                tag_q[cpu_f.set][alloc_way]  <= cpu_f.tag;
                                live_q[cpu_f.set][alloc_way] <= 1'b1;
                                wval_q[cpu_f.set][alloc_way] <= '0;
                                need_q <= '1;
                            end else begin
                                need_q <= ~wval_q[cpu_f.set][cpu_hit_way];
                            end
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        wval_q[req_q.set][way_q][fill_off] <= 1'b1;
                        need_q <= need_after;
                        if (need_after == '0) state_q <= ST_IDLE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cache_checker.sv
module cache_checker
    import cache_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              mem_ack
);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_req && !cpu_ready)); // R1

    AST_READY_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_req); // R3

    AST_MEM_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R5

    AST_STORE_GOES_OUT: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_we) |-> (mem_req && mem_we && mem_ack)); // R5

    AST_FILL_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && !cpu_we && mem_ack) |-> (cpu_rdata == mem_rdata)); // R4

    AST_FILL_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack) |=>
        (!mem_req || (!mem_we && (mem_addr[OFF_W-1:0] > $past(mem_addr[OFF_W-1:0]))))); // R4

endmodule

bind cache_top cache_checker u_cache_checker (.*);

// File: tb/cache_top_bench.sv
module cache_top_bench;
    import cache_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [11:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        dma_wr_valid = 1'b0;
    logic [11:0] dma_wr_addr = '0;

    int n_chk = 0, n_fail = 0;

    cache_top u_cache_top (.*);

    always #10 clk = ~clk;

    // Memory model
    logic [31:0] mem [4096];
    int          rd_cnt, wr_cnt, lat_cnt, rd_at_ready;
    logic [11:0] rd_log [8];
    logic [11:0] wr_addr_last;
    logic [31:0] wr_data_last;

    initial for (int i = 0; i < 4096; i++) mem[i] = 32'hA5A50000 | i;

    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
            lat_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            lat_cnt = 0;
        end else if (mem_req) begin
            if (lat_cnt == 1) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_addr_last  = mem_addr;
                    wr_data_last  = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = mem[mem_addr];
                    if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
                    rd_cnt++;
                end
            end else begin
                lat_cnt++;
            end
        end
    end

    function automatic logic [11:0] mk(int t, int s, int o);
        return {t[5:0], s[3:0], o[1:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One processor access; optional DMA pulse in the same cycle
    task automatic access(input bit we, input logic [11:0] a, input logic [31:0] d,
                          input bit with_dma, output logic [31:0] q, output int lat);
        bit done = 0;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; rd_at_ready = -1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (with_dma) begin
            dma_wr_valid = 1'b1;
            dma_wr_addr  = a;
        end
        lat = 0;
        q = '0;
        while (!done) begin
            #1;
            if (cpu_ready) begin
                q = cpu_rdata;
                rd_at_ready = rd_cnt;
                done = 1;
            end else begin
                @(negedge clk);
                dma_wr_valid = 1'b0;
                lat++;
            end
        end
        @(negedge clk);
        dma_wr_valid = 1'b0;
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
        // let any trailing fill drain
        while (mem_req) @(negedge clk);
    endtask

    task automatic dma_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        mem[a] = d;
        dma_wr_valid = 1'b1;
        dma_wr_addr  = a;
        @(negedge clk);
        dma_wr_valid = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        #1;
        check("R1 ready idle", 32'(cpu_ready), 0);
        check("R1 mem idle", 32'(mem_req), 0);
    endtask

    task automatic test_read_fill();
        logic [31:0] q; int lat;
        access(0, mk(3, 1, 2), '0, 0, q, lat);
        check("R1 R4 fill count", rd_cnt, 4);
        check("R2 R4 first word addr", 32'(rd_log[0]), 32'(mk(3, 1, 0)));
        check("R2 R4 last word addr", 32'(rd_log[3]), 32'(mk(3, 1, 3)));
        check("R4 ready on requested word", rd_at_ready, 3);
        check("R4 fill data", q, mem[mk(3, 1, 2)]);
    endtask

    task automatic test_read_hit();
        logic [31:0] q; int lat;
        access(0, mk(3, 1, 0), '0, 0, q, lat);
        check("R3 hit latency", lat, 0);
        check("R3 hit no memory", rd_cnt, 0);
        check("R3 hit data", q, mem[mk(3, 1, 0)]);
    endtask

    task automatic test_write_hit();
        logic [31:0] q; int lat;
        access(1, mk(3, 1, 1), 32'h11112222, 0, q, lat);
        check("R5 one memory write", wr_cnt, 1);
        check("R5 write addr", 32'(wr_addr_last), 32'(mk(3, 1, 1)));
        check("R5 write data", wr_data_last, 32'h11112222);
        access(0, mk(3, 1, 1), '0, 0, q, lat);
        check("R5 updated copy no reads", rd_cnt, 0);
        check("R5 updated copy data", q, 32'h11112222);
    endtask

    task automatic test_write_miss();
        logic [31:0] q; int lat;
        access(1, mk(7, 5, 3), 32'hBEEF0003, 0, q, lat);
        check("R6 no line fetch", rd_cnt, 0);
        check("R6 write through", wr_cnt, 1);
        access(0, mk(7, 5, 3), '0, 0, q, lat);
        check("R6 written word hits", rd_cnt, 0);
        check("R6 written word data", q, 32'hBEEF0003);
        access(0, mk(7, 5, 1), '0, 0, q, lat);
        check("R6 partial fill count", rd_cnt, 3);
        check("R6 partial fill first", 32'(rd_log[0]), 32'(mk(7, 5, 0)));
        check("R6 partial fill last", 32'(rd_log[2]), 32'(mk(7, 5, 2)));
        check("R6 partial fill data", q, mem[mk(7, 5, 1)]);
    endtask

    task automatic test_dma_miss();
        logic [31:0] q; int lat;
        dma_write(mk(9, 1, 0), 32'h0BAD0001);
        access(0, mk(3, 1, 0), '0, 0, q, lat);
        check("R8 other tag no effect", rd_cnt, 0);
        dma_write(mk(3, 2, 0), 32'h0BAD0002);
        access(0, mk(3, 1, 0), '0, 0, q, lat);
        check("R8 other set no effect", rd_cnt, 0);
    endtask

    task automatic test_dma_hit();
        logic [31:0] q; int lat;
        dma_write(mk(3, 1, 0), 32'hD0D0D0D0);
        access(0, mk(3, 1, 0), '0, 0, q, lat);
        check("R7 refetch count", rd_cnt, 4);
        check("R7 new data", q, 32'hD0D0D0D0);
    endtask

    task automatic test_same_cycle();
        logic [31:0] q; int lat;
        mem[mk(3, 1, 3)] = 32'h5A5A5A5A;
        access(0, mk(3, 1, 3), '0, 1, q, lat);
        check("R9 snoop first miss", rd_cnt, 4);
        check("R9 snoop first data", q, 32'h5A5A5A5A);
        access(0, mk(3, 1, 3), '0, 0, q, lat);
        check("R9 line refilled", rd_cnt, 0);
    endtask

    task automatic test_lru();
        logic [31:0] q; int lat;
        for (int t = 1; t <= 4; t++) begin
            access(0, mk(t, 9, 0), '0, 0, q, lat);
            check("R10 fill empty way", rd_cnt, 4);
        end
        access(0, mk(1, 9, 0), '0, 0, q, lat);
        check("R10 empty ways used first", rd_cnt, 0);
        access(0, mk(5, 9, 0), '0, 0, q, lat);
        check("R10 fifth tag misses", rd_cnt, 4);
        access(0, mk(1, 9, 0), '0, 0, q, lat);
        check("R10 recent way kept", rd_cnt, 0);
        access(0, mk(3, 9, 0), '0, 0, q, lat);
        check("R10 way kept", rd_cnt, 0);
        access(0, mk(4, 9, 0), '0, 0, q, lat);
        check("R10 way kept", rd_cnt, 0);
        access(0, mk(5, 9, 0), '0, 0, q, lat);
        check("R10 new tag resident", rd_cnt, 0);
        access(0, mk(2, 9, 0), '0, 0, q, lat);
        check("R10 oldest was evicted", rd_cnt, 4);
        check("R10 evicted refetch data", q, mem[mk(2, 9, 0)]);
    endtask

    bit finished = 0;

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_read_fill();
        test_read_hit();
        test_write_hit();
        test_write_miss();
        test_dma_miss();
        test_dma_hit();
        test_same_cycle();
        test_lru();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule